// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a page table held in memory. A request supplies the address, whether it is a write, and whether it comes from user mode, together with the current table base, the domain access word, the two legacy read-enable control bits (S and R) and the process relocation value. The walker fetches the first-level descriptor, then either finishes on a section mapping or fetches a second-level descriptor from a coarse or fine table. Second-level descriptors map 64 KB, 4 KB or 1 KB pages.

The result comes back with a one-cycle `done` pulse. The pulse carries either a physical address with read and write rights, or a fault flag with an 8-bit status. The status holds the fault code in its low nibble and the domain number in its high nibble. Memory is read through a one-cycle request pulse followed, some cycles later, by a one-cycle data-valid strobe.

Top module: `ptw_walker`

## Requirements
- R1: An address below 0x02000000 has `pid_reloc` added to it (modulo 2^32) when the request is accepted. Addresses at or above 0x02000000 are used unchanged. All later address arithmetic uses the adjusted value.
- R2: The first-level fetch address is `{tbase[31:14], va[31:20], 2'b00}`. Each fetch is a single-cycle `mem_req` pulse. The walker waits for `mem_rvalid` before it decodes the data, and it makes at most two fetches per walk.
- R3: The type field is bits [1:0] of the first-level descriptor. Type 0 faults with code 5. Type 2 is a section. Type 1 points to a coarse table and type 3 points to a fine table.
- R4: The domain number is bits [8:5] of the first-level descriptor. Its access value is `dom_ctl[2*dom+1:2*dom]`. Access values 0 and 2 fault with code 9 for a section and code 11 for a table; a table that faults this way causes no second fetch. Access value 3 grants read and write whatever the permission field holds.
- R5: A section maps to `{desc[31:20], va[19:0]}`. Its permission field is desc[11:10], and a permission failure on a section gives code 13.
- R6: The second-level fetch address is `{desc[31:10], va[19:12], 2'b00}` for a coarse table and `{desc[31:12], va[19:10], 2'b00}` for a fine table.
- R7: The second-level type field is bits [1:0] of the second-level descriptor. Type 0 faults with code 7. Type 1 maps `{desc[31:16], va[15:0]}` and type 2 maps `{desc[31:12], va[11:0]}`; both take their permission field from bits `[5+2*va[15:14] : 4+2*va[15:14]]`. Type 3 maps `{desc[31:10], va[9:0]}` with permission field desc[5:4].
- R8: Permission field 0 never allows a write. For a read it grants read-only access when R is set, or when S is set and the access is privileged. Otherwise it denies the access.
- R9: Permission field 1 gives read/write to privileged accesses only. Field 2 gives read/write to privileged accesses and read-only to user accesses. Field 3 gives read/write to all. A denied page access faults with code 15.
- R10: On a fault, `fault_status = {domain, code}`, and `pa`, `perm_rd` and `perm_wr` are zero. On success, `fault` and `fault_status` are zero and the rights are reported as granted.
- R11: `done` is high for exactly one cycle per accepted request, and the results are valid in that cycle. A request is accepted only while idle, and `req_valid` during a walk is ignored. The configuration inputs are sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (accepted when idle) |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| tbase | input | 32 | Translation table base |
| dom_ctl | input | 32 | Sixteen 2-bit domain access fields |
| ctl_s | input | 1 | Privileged read enable for permission 0 |
| ctl_r | input | 1 | Universal read enable for permission 0 |
| pid_reloc | input | 32 | Relocation added to low addresses |
| mem_req | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor address |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_status | output | 8 | {domain, code} on fault |
| pa | output | 32 | Physical address |
| perm_rd | output | 1 | Read granted |
| perm_wr | output | 1 | Write granted |

## Verification
Some internal errors show up at the ports within the same walk. A state register stuck in the wrong place shows as a missing or extra fetch, or a `done` pulse that never comes or repeats. A wrong field index shows as a mismatched fetch address, physical address or status nibble in the `done` cycle. The sweep covers every combination of first-level type, domain access value, permission field, user and write flags, S/R setting and second-level type. Each combination uses a fresh address and a varied memory latency. A second-level descriptor holds the complement in its unselected permission fields, so a wrong subpage choice changes the result.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] tbase,
  input  logic [31:0] dom_ctl,
  input  logic        ctl_s,
  input  logic        ctl_r,
  input  logic [31:0] pid_reloc,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [7:0]  fault_status,
  output logic [31:0] pa,
  output logic        perm_rd,
  output logic        perm_wr
);
  localparam logic [3:0] FC_SEC_XLT  = 4'h5;
  localparam logic [3:0] FC_PG_XLT   = 4'h7;
  localparam logic [3:0] FC_SEC_DOM  = 4'h9;
  localparam logic [3:0] FC_PG_DOM   = 4'hB;
  localparam logic [3:0] FC_SEC_PERM = 4'hD;
  localparam logic [3:0] FC_PG_PERM  = 4'hF;

  typedef enum logic [2:0] {IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, DONE} st_t;

  st_t         st;
  logic [31:0] va_q, ttb_q, dacr_q, d1_q, pa_q;
  logic        wr_q, usr_q, s_q, r_q;
  logic        flt_q, prd_q, pwr_q;
  logic [7:0]  fs_q;

  function automatic logic [1:0] ap_rights(input logic [1:0] ap, input logic w,
                                           input logic u, input logic s, input logic r);
    case (ap)
      2'd0:    ap_rights = w ? 2'b00 : ((r || (s && !u)) ? 2'b10 : 2'b00);
      2'd1:    ap_rights = u ? 2'b00 : 2'b11;
      2'd2:    ap_rights = u ? (w ? 2'b00 : 2'b10) : 2'b11;
      default: ap_rights = 2'b11;
    endcase
  endfunction

  wire [31:0] d1      = (st == L1_WAIT) ? mem_rdata : d1_q;
  wire [3:0]  dom     = d1[8:5];
  wire [1:0]  dac     = dacr_q[{dom, 1'b0} +: 2];
  wire        manager = (dac == 2'b11);

  wire [1:0]  t1      = mem_rdata[1:0];
  wire [1:0]  rt_sec  = manager ? 2'b11 : ap_rights(mem_rdata[11:10], wr_q, usr_q, s_q, r_q);

  wire [7:0]  apf     = mem_rdata[11:4];
  wire [2:0]  apsel   = {va_q[15:14], 1'b0};
  wire [1:0]  ap_l2   = (t1 == 2'd3) ? mem_rdata[5:4] : apf[apsel +: 2];
  wire [1:0]  rt_l2   = manager ? 2'b11 : ap_rights(ap_l2, wr_q, usr_q, s_q, r_q);

  logic [31:0] pa_l2;
  always_comb begin
    case (t1)
      2'd1:    pa_l2 = {mem_rdata[31:16], va_q[15:0]};
      2'd2:    pa_l2 = {mem_rdata[31:12], va_q[11:0]};
      default: pa_l2 = {mem_rdata[31:10], va_q[9:0]};
    endcase
  end

  wire [31:0] l1_addr = {ttb_q[31:14], va_q[31:20], 2'b00};
  wire [31:0] l2_addr = (d1_q[1:0] == 2'd1) ? {d1_q[31:10], va_q[19:12], 2'b00}
                                            : {d1_q[31:12], va_q[19:10], 2'b00};

  assign mem_req      = (st == L1_REQ) || (st == L2_REQ);
  assign mem_addr     = (st == L1_REQ) ? l1_addr : l2_addr;
  assign done         = (st == DONE);
  assign fault        = flt_q;
  assign fault_status = fs_q;
  assign pa           = pa_q;
  assign perm_rd      = prd_q;
  assign perm_wr      = pwr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      va_q   <= '0;
      ttb_q  <= '0;
      dacr_q <= '0;
      d1_q   <= '0;
      pa_q   <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      s_q    <= 1'b0;
      r_q    <= 1'b0;
      flt_q  <= 1'b0;
      prd_q  <= 1'b0;
      pwr_q  <= 1'b0;
      fs_q   <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va_q   <= (req_va < RELOC_LIMIT) ? req_va + pid_reloc : req_va;
          wr_q   <= req_write;
          usr_q  <= req_user;
          ttb_q  <= tbase;
          dacr_q <= dom_ctl;
          s_q    <= ctl_s;
          r_q    <= ctl_r;
          st     <= L1_REQ;
        end
        L1_REQ: st <= L1_WAIT;
        L1_WAIT: if (mem_rvalid) begin
          d1_q  <= mem_rdata;
          st    <= DONE;
          flt_q <= 1'b1;
          prd_q <= 1'b0;
          pwr_q <= 1'b0;
          pa_q  <= '0;
          if (t1 == 2'd0) begin
            fs_q <= {dom, FC_SEC_XLT};
          end else if (!dac[0]) begin
            fs_q <= {dom, (t1 == 2'd2) ? FC_SEC_DOM : FC_PG_DOM};
          end else if (t1 == 2'd2) begin
            if (rt_sec == 2'b00) begin
              fs_q <= {dom, FC_SEC_PERM};
            end else begin
              flt_q          <= 1'b0;
              fs_q           <= '0;
              pa_q           <= {mem_rdata[31:20], va_q[19:0]};
              {prd_q, pwr_q} <= rt_sec;
            end
          end else begin
            st <= L2_REQ;
          end
        end
        L2_REQ: st <= L2_WAIT;
        L2_WAIT: if (mem_rvalid) begin
          st    <= DONE;
          flt_q <= 1'b1;
          prd_q <= 1'b0;
          pwr_q <= 1'b0;
          pa_q  <= '0;
          if (t1 == 2'd0) begin
            fs_q <= {dom, FC_PG_XLT};
          end else if (rt_l2 == 2'b00) begin
            fs_q <= {dom, FC_PG_PERM};
          end else begin
            flt_q          <= 1'b0;
            fs_q           <= '0;
            pa_q           <= pa_l2;
            {prd_q, pwr_q} <= rt_l2;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       done,
  input logic       fault,
  input logic [7:0] fault_status,
  input logic       perm_rd,
  input logic       perm_wr,
  input logic       wr_q
);
  a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r2_no_fetch_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fault_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (!perm_rd && !perm_wr));

  a_r10_fault_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_status[0] && fault_status[3:0] >= 4'h5));

  a_r9_success_readable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> perm_rd);

  a_r8_write_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && wr_q) |-> perm_wr);
endmodule

bind ptw_walker ptw_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .done(done), .fault(fault),
  .fault_status(fault_status), .perm_rd(perm_rd), .perm_wr(perm_wr), .wr_q(wr_q)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] tbase = '0;
  logic [31:0] dom_ctl = '0;
  logic        ctl_s = 1'b0;
  logic        ctl_r = 1'b0;
  logic [31:0] pid_reloc = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault, perm_rd, perm_wr;
  logic [7:0]  fault_status;
  logic [31:0] pa;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .tbase(tbase), .dom_ctl(dom_ctl),
    .ctl_s(ctl_s), .ctl_r(ctl_r), .pid_reloc(pid_reloc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_status(fault_status), .pa(pa),
    .perm_rd(perm_rd), .perm_wr(perm_wr)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [31:0] d1_v, d2_v, seed;
  logic [31:0] fa [4];
  int nfetch = 0;
  int lat = 1;
  int lat_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed ^ (seed >> 15);
  endfunction

  function automatic logic [1:0] ref_rights(input logic [1:0] ap, input bit w, input bit u,
                                            input bit s, input bit r);
    if (ap == 2'd0) return w ? 2'b00 : ((r || (s && !u)) ? 2'b10 : 2'b00);
    if (ap == 2'd1) return u ? 2'b00 : 2'b11;
    if (ap == 2'd2) return u ? (w ? 2'b00 : 2'b10) : 2'b11;
    return 2'b11;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%08h expected=%08h", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (lat_cnt != 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = (nfetch == 1) ? d1_v : d2_v;
      end
    end else begin
      mem_rvalid = 1'b0;
      if (rst_n && mem_req) begin
        if (nfetch < 4) fa[nfetch] = mem_addr;
        nfetch++;
        lat_cnt = lat;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] pid, input logic [31:0] ttb,
                      input logic [31:0] dacr, input bit s, input bit r, input bit w,
                      input bit u, input logic [31:0] d1, input logic [31:0] d2, input bit poke);
    logic [31:0] va2, l1a, l2a, epa;
    logic [3:0]  dom, code;
    logic [1:0]  dac, rt, ap;
    int          efetch, waited;
    string       ptag;
    va2  = (va < 32'h0200_0000) ? va + pid : va;
    ptag = (va < 32'h0200_0000) ? "R1" : "R5";
    l1a  = {ttb[31:14], va2[31:20], 2'b00};
    dom  = d1[8:5];
    dac  = dacr[2*dom +: 2];
    l2a  = (d1[1:0] == 2'd1) ? {d1[31:10], va2[19:12], 2'b00} : {d1[31:12], va2[19:10], 2'b00};
    code = 4'h0; epa = '0; rt = 2'b00; efetch = 1;
    if (d1[1:0] == 2'd0) code = 4'h5;
    else if (dac == 2'd0 || dac == 2'd2) code = (d1[1:0] == 2'd2) ? 4'h9 : 4'hB;
    else if (d1[1:0] == 2'd2) begin
      rt = (dac == 2'd3) ? 2'b11 : ref_rights(d1[11:10], w, u, s, r);
      if (rt == 2'b00) code = 4'hD;
      else epa = (d1 & 32'hFFF0_0000) | (va2 & 32'h000F_FFFF);
    end else begin
      efetch = 2;
      if (d2[1:0] == 2'd0) code = 4'h7;
      else begin
        if (d2[1:0] == 2'd3) ap = d2[5:4];
        else ap = 2'((d2 >> (4 + ((va2 >> 13) & 6))) & 3);
        rt = (dac == 2'd3) ? 2'b11 : ref_rights(ap, w, u, s, r);
        if (rt == 2'b00) code = 4'hF;
        else if (d2[1:0] == 2'd1) epa = (d2 & 32'hFFFF_0000) | (va2 & 32'h0000_FFFF);
        else if (d2[1:0] == 2'd2) epa = (d2 & 32'hFFFF_F000) | (va2 & 32'h0000_0FFF);
        else epa = (d2 & 32'hFFFF_FC00) | (va2 & 32'h0000_03FF);
      end
    end
    if (code != 4'h0) rt = 2'b00;

    d1_v = d1; d2_v = d2; nfetch = 0;
    req_va = va; pid_reloc = pid; tbase = ttb; dom_ctl = dacr;
    ctl_s = s; ctl_r = r; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R11: configuration changes after acceptance must not matter
    tbase = ~ttb; dom_ctl = ~dacr; pid_reloc = ~pid; req_va = ~va;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (!done && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R11 done pulse arrives", {31'd0, done}, 32'd1);
    chk(fault == (code != 4'h0), "R10 fault flag", {31'd0, fault}, {31'd0, code != 4'h0});
    chk(fault_status == {(code != 4'h0) ? dom : 4'h0, code},
        (code == 4'h5) ? "R3 l1 type fault status" : (code == 4'h7) ? "R7 l2 type fault status" :
        (code == 4'h9 || code == 4'hB) ? "R4 domain fault status" :
        (code == 4'hD) ? "R5 section permission status" :
        (code == 4'hF) ? "R9 page permission status" : "R10 clean status",
        {24'd0, fault_status}, {24'd0, (code != 4'h0) ? dom : 4'h0, code});
    chk(pa == epa, (efetch == 2) ? "R7 page address" : ptag, pa, epa);
    chk({perm_rd, perm_wr} == rt, (dac == 2'd3) ? "R4 manager rights" : "R8 R9 rights",
        {30'd0, perm_rd, perm_wr}, {30'd0, rt});
    chk(fa[0] == l1a, "R2 first-level address", fa[0], l1a);
    if (efetch == 2) chk(fa[1] == l2a, "R6 second-level address", fa[1], l2a);
    @(negedge clk);
    chk(done == 1'b0, "R11 done is one cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(nfetch == efetch, poke ? "R11 request during walk ignored" : "R4 fetch count",
        nfetch, efetch);
  endtask

  initial begin
    logic [31:0] va, d1, d2, dacr;
    logic [3:0]  dom;
    int          n;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_req == 1'b0, "R11 reset state", {30'd0, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && mem_req == 1'b0, "R11 idle after reset", {30'd0, done, mem_req}, 32'd0);

    // R1 boundary: just below and exactly at the relocation limit, manager section
    walk(32'h01FF_FFFF, 32'h0600_0000, 32'h0004_0000, 32'hFFFF_FFFF, 0, 0, 1, 1,
         32'hABC0_0002, 32'h0, 0);
    walk(32'h0200_0000, 32'h0600_0000, 32'h0004_0000, 32'hFFFF_FFFF, 0, 0, 1, 1,
         32'hABC0_0002, 32'h0, 0);

    n = 0;
    for (int t1 = 0; t1 < 4; t1++)
      for (int dac = 0; dac < 4; dac++)
        for (int ap = 0; ap < 4; ap++)
          for (int md = 0; md < 16; md++)
            for (int t2 = 0; t2 < ((t1 == 1 || t1 == 3) ? 4 : 1); t2++) begin
              n++;
              lat = 1 + (n % 3);
              va = rnd();
              if (n % 4 == 0) va = va & 32'h01FF_FFFF;
              dom = 4'(rnd());
              dacr = (rnd() & ~(32'd3 << (2 * dom))) | (32'(dac) << (2 * dom));
              d1 = (rnd() & ~32'h0000_0DE3) | (32'(ap) << 10) | (32'(dom) << 5) | 32'(t1);
              d2 = rnd() & ~32'h0000_0FF3;
              if (t2 == 3) d2 = d2 | (32'(ap) << 4) | (rnd() & 32'h0000_0FC0);
              else begin
                logic [31:0] vr;
                int sel;
                vr  = (va < 32'h0200_0000) ? va + 32'h5A00_0000 : va;
                sel = int'((vr >> 14) & 3);
                for (int k = 0; k < 4; k++)
                  d2 = d2 | (32'((k == sel) ? ap : (~ap & 3)) << (4 + 2 * k));
              end
              d2 = d2 | 32'(t2);
              walk(va, 32'h5A00_0000, rnd(), dacr, md[0], md[1], md[2], md[3], d1, d2, (n % 7) == 0);
            end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule